// File: doc/BRIEF.md
# Inter-Thread Doorbell Router

The router sits between the hardware threads of a small multi-threaded cluster and their interrupt logic. Each cycle, any thread may present one doorbell command: a send that raises a doorbell pending bit on one or more target threads, or a clear that lowers a pending bit on the issuing thread itself. The router decodes each command's kind, message type, broadcast flag and target tag. It merges the effects of all issuers and updates three per-thread pending vectors: normal, critical and hypervisor doorbells.

Three command kinds are supported. Embedded-style sends pick targets by processor-ID match or by broadcast. Server-style sends pick one thread by processor ID and may widen to that thread's whole core. Core-local sends pick a sibling thread by index. Message types that have no assigned meaning are dropped silently. A global single-thread mode input narrows core-local targeting and server-style broadcast. The block is a single registered stage with no sequencing states: every command takes effect at the next clock edge.

Top module: `dbr_router`

## Requirements
- R1: While `rst` is high at a clock edge, all three pending vectors become zero.
- R2: An embedded-style command (kind 0) sends type 0 to the normal vector and type 1 to the critical vector, on every thread whose processor ID equals the tag. More than one thread may match.
- R3: An embedded-style send with the broadcast bit set targets every thread, whatever the tag.
- R4: Embedded-style commands with types 2 to 7 have no effect, whether they are sends or clears. This covers the guest doorbell types 2, 3 and 4.
- R5: A server-style command (kind 1) is valid only with type 5, and it acts on the hypervisor vector. A send sets the bit of the lowest-numbered thread whose processor ID equals the tag. Other types, and tags that match no thread, have no effect. Kind 3 commands always have no effect.
- R6: A server-style send with the broadcast bit set targets every thread in the core of the matched thread, where the core number is the thread number divided by `TPC`. When `st_mode` is high, only the matched thread is targeted.
- R7: A core-local command (kind 2) is valid only with type 5, and it acts on the normal vector. A send uses tag bits [6:0] as an index and sets the thread at that index within the issuer's core. An index of `TPC` or above is ignored. When `st_mode` is high, index 0 sets the issuer's own bit and any other index is ignored.
- R8: A clear (`cmd_clr` high) with a valid kind and type lowers only the issuing thread's bit, and only in the vector for that class.
- R9: If a set and a clear hit the same thread and class in the same cycle, the bit ends set.
- R10: Every effect appears at the first clock edge after the command is presented. When no command is valid, the pending vectors hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_mode | input | 1 | Single-thread mode |
| pid_all | input | NTHR*TAG_W | Processor ID of each thread; thread j uses bits [j*TAG_W +: TAG_W] |
| cmd_vld | input | NTHR | Command valid, one bit per issuing thread |
| cmd_clr | input | NTHR | 1 = clear, 0 = send |
| cmd_kind | input | 2*NTHR | Command kind: 0 embedded, 1 server, 2 core-local, 3 reserved |
| cmd_type | input | 3*NTHR | Message type |
| cmd_bcast | input | NTHR | Broadcast flag |
| cmd_tag | input | NTHR*TAG_W | Target processor-ID tag, or thread index in bits [6:0] |
| pend_norm | output | NTHR | Normal doorbell pending bits |
| pend_crit | output | NTHR | Critical doorbell pending bits |
| pend_hyp | output | NTHR | Hypervisor doorbell pending bits |

## Verification
The assertions assume that the pending bits change only through commands. A rising bit is traced back to some valid send in the previous cycle, and a falling bit is traced back to a clear from that same thread. They also assume that `pid_all` and `st_mode` are stable across a command's cycle. The stimulus changes these inputs only at the falling edge, and it includes duplicate processor IDs so that multi-target matching and lowest-index selection are both exercised.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    typedef enum logic [1:0] {
        KIND_EMB  = 2'd0,
        KIND_SRV  = 2'd1,
        KIND_CORE = 2'd2,
        KIND_RSV  = 2'd3
    } kind_e;

    localparam logic [2:0] TY_NORM = 3'd0;
    localparam logic [2:0] TY_CRIT = 3'd1;
    localparam logic [2:0] TY_SRV  = 3'd5;

    localparam int NCLS = 3;
    localparam int CLS_N = 0;
    localparam int CLS_C = 1;
    localparam int CLS_H = 2;
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int TPC   = 2,
    parameter int TAG_W = 8,
    parameter int SELF  = 0
) (
    input  logic                    vld,
    input  logic                    clr,
    input  logic [1:0]              kind,
    input  logic [2:0]              mtype,
    input  logic                    bcast,
    input  logic [TAG_W-1:0]        tag,
    input  logic [NTHR*TAG_W-1:0]   pid_all,
    input  logic                    st_mode,
    output logic [NTHR-1:0]         set_n,
    output logic [NTHR-1:0]         set_c,
    output logic [NTHR-1:0]         set_h,
    output logic [NTHR-1:0]         clr_n,
    output logic [NTHR-1:0]         clr_c,
    output logic [NTHR-1:0]         clr_h
);
    localparam int IDX_W     = 7;
    localparam int CORE_BASE = (SELF / TPC) * TPC;
    localparam logic [NTHR-1:0] SELF_BIT = NTHR'(1) << SELF;

    logic [NTHR-1:0]  match;
    logic [NTHR-1:0]  tgt;
    logic             found;
    int               sel;
    logic             use_n, use_c, use_h;
    logic             send, drop;
    logic [IDX_W-1:0] idx;

    assign idx  = tag[IDX_W-1:0];
    assign send = vld && !clr;
    assign drop = vld && clr;

    always_comb begin
        for (int j = 0; j < NTHR; j++) begin
            match[j] = (pid_all[j*TAG_W +: TAG_W] == tag);
        end
    end

    always_comb begin
        sel   = 0;
        found = 1'b0;
        for (int j = NTHR - 1; j >= 0; j--) begin
            if (match[j]) begin
                sel   = j;
                found = 1'b1;
            end
        end
    end

    always_comb begin
        use_n = 1'b0;
        use_c = 1'b0;
        use_h = 1'b0;
        unique case (kind_e'(kind))
            KIND_EMB: begin
                use_n = (mtype == TY_NORM);
                use_c = (mtype == TY_CRIT);
            end
            KIND_SRV:  use_h = (mtype == TY_SRV);
            KIND_CORE: use_n = (mtype == TY_SRV);
            KIND_RSV:  ;
        endcase
    end

    always_comb begin
        tgt = '0;
        unique case (kind_e'(kind))
            KIND_EMB: tgt = bcast ? '1 : match;
            KIND_SRV: begin
                if (found) begin
                    for (int j = 0; j < NTHR; j++) begin
                        tgt[j] = (j == sel) ||
                                 (bcast && !st_mode && ((j / TPC) == (sel / TPC)));
                    end
                end
            end
            KIND_CORE: begin
                if (st_mode) begin
                    if (idx == '0) tgt = SELF_BIT;
                end else begin
                    for (int j = 0; j < TPC; j++) begin
                        if (idx == IDX_W'(j)) tgt[CORE_BASE + j] = 1'b1;
                    end
                end
            end
            KIND_RSV: ;
        endcase
    end

    assign set_n = (send && use_n) ? tgt : '0;
    assign set_c = (send && use_c) ? tgt : '0;
    assign set_h = (send && use_h) ? tgt : '0;
    assign clr_n = (drop && use_n) ? SELF_BIT : '0;
    assign clr_c = (drop && use_c) ? SELF_BIT : '0;
    assign clr_h = (drop && use_h) ? SELF_BIT : '0;
endmodule

// File: rtl/dbr_pend.sv
module dbr_pend #(
    parameter int NTHR = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NTHR-1:0] set_m,
    input  logic [NTHR-1:0] clr_m,
    output logic [NTHR-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= (q & ~clr_m) | set_m;
        end
    end
endmodule

// File: rtl/dbr_router.sv
module dbr_router
    import dbr_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int TPC   = 2,
    parameter int TAG_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   st_mode,
    input  logic [NTHR*TAG_W-1:0]  pid_all,
    input  logic [NTHR-1:0]        cmd_vld,
    input  logic [NTHR-1:0]        cmd_clr,
    input  logic [2*NTHR-1:0]      cmd_kind,
    input  logic [3*NTHR-1:0]      cmd_type,
    input  logic [NTHR-1:0]        cmd_bcast,
    input  logic [NTHR*TAG_W-1:0]  cmd_tag,
    output logic [NTHR-1:0]        pend_norm,
    output logic [NTHR-1:0]        pend_crit,
    output logic [NTHR-1:0]        pend_hyp
);
    logic [NTHR-1:0] sn_m [NTHR];
    logic [NTHR-1:0] sc_m [NTHR];
    logic [NTHR-1:0] sh_m [NTHR];
    logic [NTHR-1:0] cn_m [NTHR];
    logic [NTHR-1:0] cc_m [NTHR];
    logic [NTHR-1:0] ch_m [NTHR];
    logic [NTHR-1:0] set_v [NCLS];
    logic [NTHR-1:0] clr_v [NCLS];
    logic [NTHR-1:0] pend_v [NCLS];

    for (genvar g = 0; g < NTHR; g++) begin : g_dec
        dbr_decode #(
            .NTHR(NTHR), .TPC(TPC), .TAG_W(TAG_W), .SELF(g)
        ) u_dec (
            .vld     (cmd_vld[g]),
            .clr     (cmd_clr[g]),
            .kind    (cmd_kind[2*g +: 2]),
            .mtype   (cmd_type[3*g +: 3]),
            .bcast   (cmd_bcast[g]),
            .tag     (cmd_tag[g*TAG_W +: TAG_W]),
            .pid_all (pid_all),
            .st_mode (st_mode),
            .set_n   (sn_m[g]),
            .set_c   (sc_m[g]),
            .set_h   (sh_m[g]),
            .clr_n   (cn_m[g]),
            .clr_c   (cc_m[g]),
            .clr_h   (ch_m[g])
        );
    end

    always_comb begin
        for (int c = 0; c < NCLS; c++) begin
            set_v[c] = '0;
            clr_v[c] = '0;
        end
        for (int g = 0; g < NTHR; g++) begin
            set_v[CLS_N] = set_v[CLS_N] | sn_m[g];
            set_v[CLS_C] = set_v[CLS_C] | sc_m[g];
            set_v[CLS_H] = set_v[CLS_H] | sh_m[g];
            clr_v[CLS_N] = clr_v[CLS_N] | cn_m[g];
            clr_v[CLS_C] = clr_v[CLS_C] | cc_m[g];
            clr_v[CLS_H] = clr_v[CLS_H] | ch_m[g];
        end
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_pend
        dbr_pend #(.NTHR(NTHR)) u_pend (
            .clk   (clk),
            .rst   (rst),
            .set_m (set_v[c]),
            .clr_m (clr_v[c]),
            .q     (pend_v[c])
        );
    end

    assign pend_norm = pend_v[CLS_N];
    assign pend_crit = pend_v[CLS_C];
    assign pend_hyp  = pend_v[CLS_H];
endmodule

// File: rtl/dbr_router_chk.sv
module dbr_router_chk #(
    parameter int NTHR  = 4,
    parameter int TAG_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NTHR-1:0]       cmd_vld,
    input logic [NTHR-1:0]       cmd_clr,
    input logic [2*NTHR-1:0]     cmd_kind,
    input logic [3*NTHR-1:0]     cmd_type,
    input logic [NTHR-1:0]       pend_norm,
    input logic [NTHR-1:0]       pend_crit,
    input logic [NTHR-1:0]       pend_hyp
);
    logic any_send, emb_send, srv_bad_only;

    always_comb begin
        any_send     = |(cmd_vld & ~cmd_clr);
        emb_send     = 1'b0;
        srv_bad_only = |cmd_vld;
        for (int i = 0; i < NTHR; i++) begin
            if (cmd_vld[i] && !cmd_clr[i] && cmd_kind[2*i +: 2] == 2'd0) emb_send = 1'b1;
            if (cmd_vld[i] && (cmd_kind[2*i +: 2] != 2'd1 || cmd_type[3*i +: 3] == 3'd5))
                srv_bad_only = 1'b0;
        end
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld == '0) |=> ($stable(pend_norm) && $stable(pend_crit) && $stable(pend_hyp)));

    // R2
    rise_needs_send_chk: assert property (@(posedge clk) disable iff (rst)
        (((pend_norm & ~$past(pend_norm)) | (pend_crit & ~$past(pend_crit)) |
          (pend_hyp & ~$past(pend_hyp))) != '0) |-> $past(any_send));

    // R2
    crit_from_emb_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_crit & ~$past(pend_crit)) != '0) |-> $past(emb_send));

    // R5
    srv_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        srv_bad_only |=> ($stable(pend_norm) && $stable(pend_crit) && $stable(pend_hyp)));

    for (genvar i = 0; i < NTHR; i++) begin : g_own
        // R8
        own_clear_chk: assert property (@(posedge clk) disable iff (rst)
            ($fell(pend_norm[i]) || $fell(pend_crit[i]) || $fell(pend_hyp[i]))
            |-> $past(cmd_vld[i] && cmd_clr[i]));
    end
endmodule

bind dbr_router dbr_router_chk #(.NTHR(NTHR), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_vld   (cmd_vld),
    .cmd_clr   (cmd_clr),
    .cmd_kind  (cmd_kind),
    .cmd_type  (cmd_type),
    .pend_norm (pend_norm),
    .pend_crit (pend_crit),
    .pend_hyp  (pend_hyp)
);

// File: tb/sim_dbr_router.sv
`timescale 1ns/1ps
module sim_dbr_router;
    localparam int NT = 4;
    localparam int TPC = 2;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic st_mode = 1'b0;
    logic [NT*TW-1:0] pid_all;
    logic [NT-1:0] cmd_vld, cmd_clr, cmd_bcast;
    logic [2*NT-1:0] cmd_kind;
    logic [3*NT-1:0] cmd_type;
    logic [NT*TW-1:0] cmd_tag;
    logic [NT-1:0] pend_norm, pend_crit, pend_hyp;

    int b_vld [NT], b_clr [NT], b_kind [NT], b_type [NT], b_bc [NT], b_tag [NT], b_pid [NT];
    logic [NT-1:0] exp_v [3];
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dbr_router #(.NTHR(NT), .TPC(TPC), .TAG_W(TW)) u0 (
        .clk(clk), .rst(rst), .st_mode(st_mode), .pid_all(pid_all),
        .cmd_vld(cmd_vld), .cmd_clr(cmd_clr), .cmd_kind(cmd_kind),
        .cmd_type(cmd_type), .cmd_bcast(cmd_bcast), .cmd_tag(cmd_tag),
        .pend_norm(pend_norm), .pend_crit(pend_crit), .pend_hyp(pend_hyp)
    );

    task automatic pack();
        for (int i = 0; i < NT; i++) begin
            cmd_vld[i] = (b_vld[i] != 0);
            cmd_clr[i] = (b_clr[i] != 0);
            cmd_bcast[i] = (b_bc[i] != 0);
            cmd_kind[2*i +: 2] = 2'(b_kind[i]);
            cmd_type[3*i +: 3] = 3'(b_type[i]);
            cmd_tag[i*TW +: TW] = TW'(b_tag[i]);
            pid_all[i*TW +: TW] = TW'(b_pid[i]);
        end
    endtask

    task automatic idle_all();
        for (int i = 0; i < NT; i++) begin
            b_vld[i] = 0; b_clr[i] = 0; b_kind[i] = 0; b_type[i] = 0; b_bc[i] = 0; b_tag[i] = 0;
        end
    endtask

    task automatic cmd(int i, int clr, int kind, int ty, int bc, int tag);
        b_vld[i] = 1; b_clr[i] = clr; b_kind[i] = kind; b_type[i] = ty; b_bc[i] = bc; b_tag[i] = tag;
    endtask

    task automatic model();
        logic [NT-1:0] s [3];
        logic [NT-1:0] c [3];
        for (int k = 0; k < 3; k++) begin s[k] = '0; c[k] = '0; end
        for (int i = 0; i < NT; i++) begin
            int cls;
            int tq[$];
            if (b_vld[i] == 0) continue;
            cls = -1;
            if (b_kind[i] == 0) cls = (b_type[i] == 0) ? 0 : (b_type[i] == 1) ? 1 : -1;
            else if (b_kind[i] == 1) cls = (b_type[i] == 5) ? 2 : -1;
            else if (b_kind[i] == 2) cls = (b_type[i] == 5) ? 0 : -1;
            if (cls < 0) continue;
            if (b_clr[i] != 0) begin
                c[cls][i] = 1'b1;
                continue;
            end
            if (b_kind[i] == 0) begin
                for (int j = 0; j < NT; j++) if (b_bc[i] != 0 || b_pid[j] == b_tag[i]) tq.push_back(j);
            end else if (b_kind[i] == 1) begin
                int first = -1;
                for (int j = 0; j < NT; j++) if (first < 0 && b_pid[j] == b_tag[i]) first = j;
                if (first >= 0) begin
                    if (b_bc[i] != 0 && !st_mode) begin
                        for (int j = 0; j < NT; j++) if (j / TPC == first / TPC) tq.push_back(j);
                    end else tq.push_back(first);
                end
            end else begin
                int ix = b_tag[i] % 128;
                if (st_mode) begin
                    if (ix == 0) tq.push_back(i);
                end else if (ix < TPC) tq.push_back((i / TPC) * TPC + ix);
            end
            foreach (tq[q]) s[cls][tq[q]] = 1'b1;
        end
        for (int k = 0; k < 3; k++) exp_v[k] = (exp_v[k] & ~c[k]) | s[k];
    endtask

    task automatic check(string req);
        total++;
        if (pend_norm !== exp_v[0] || pend_crit !== exp_v[1] || pend_hyp !== exp_v[2]) begin
            bad++;
            $display("FAIL %s: actual n=%b c=%b h=%b expected n=%b c=%b h=%b",
                     req, pend_norm, pend_crit, pend_hyp, exp_v[0], exp_v[1], exp_v[2]);
        end
    endtask

    task automatic step(string req);
        pack();
        model();
        @(posedge clk);
        @(negedge clk);
        check(req);
        idle_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        b_pid[0] = 8'h10; b_pid[1] = 8'h11; b_pid[2] = 8'h12; b_pid[3] = 8'h11;
        idle_all();
        pack();
        for (int k = 0; k < 3; k++) exp_v[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1");

        cmd(0, 0, 0, 0, 0, 8'h11); step("R2");          // normal on 1 and 3
        cmd(2, 0, 0, 1, 0, 8'h10); step("R2");          // critical on 0
        cmd(1, 0, 0, 3, 1, 8'h10); step("R4");          // guest type ignored
        cmd(1, 1, 0, 2, 0, 8'h11); step("R4");          // guest clear ignored
        cmd(3, 0, 0, 0, 1, 8'h77); step("R3");          // broadcast normal
        cmd(0, 1, 0, 0, 0, 8'h00); step("R8");          // own normal clear
        cmd(1, 0, 1, 4, 0, 8'h12); step("R5");          // reserved server type
        cmd(1, 0, 1, 5, 0, 8'h55); step("R5");          // no match
        cmd(2, 0, 3, 5, 1, 8'h10); step("R5");          // kind 3 ignored
        cmd(0, 0, 1, 5, 0, 8'h11); step("R5");          // lowest match: thread 1
        cmd(0, 0, 1, 5, 1, 8'h12); step("R6");          // core 1 broadcast
        for (int i = 0; i < NT; i++) cmd(i, 1, 1, 5, 0, 0);
        step("R8");
        st_mode = 1'b1;
        cmd(3, 0, 1, 5, 1, 8'h10); step("R6");          // single: thread 0 only
        for (int i = 0; i < NT; i++) cmd(i, 1, 2, 5, 0, 0);
        step("R8");
        cmd(2, 0, 2, 5, 0, 8'h80); step("R7");          // idx 0 -> self
        cmd(0, 0, 2, 5, 0, 8'h01); step("R7");          // idx 1 ignored single
        st_mode = 1'b0;
        cmd(0, 0, 2, 5, 0, 8'h01); step("R7");          // sibling 1
        cmd(2, 0, 2, 5, 0, 8'h05); step("R7");          // out of range
        cmd(3, 0, 2, 5, 0, 8'h00); step("R7");          // thread 2
        cmd(2, 0, 0, 1, 0, 8'h11); step("R2");          // crit 1 and 3
        cmd(1, 1, 0, 1, 0, 0); cmd(0, 0, 0, 1, 0, 8'h11); step("R9");
        cmd(3, 1, 0, 1, 0, 0); cmd(2, 0, 0, 1, 1, 0); step("R9");
        step("R10");
        step("R10");

        for (int n = 0; n < 400; n++) begin
            if (n % 50 == 0) st_mode = ($urandom % 4) == 0;
            for (int i = 0; i < NT; i++) begin
                if (($urandom % 3) != 0) begin
                    int r = $urandom % 6;
                    cmd(i, $urandom % 2, $urandom % 4,
                        ($urandom % 2) ? 5 : $urandom % 8, $urandom % 2,
                        (r < 4) ? 8'h10 + r : $urandom % 4);
                end
            end
            step("R10");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule